// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Associative Side Buffer

This block is a first-level, read-only, direct-mapped cache backed by a tiny fully-associative side buffer between the cache array and its refill path. A processor read looks in the direct-mapped array first. When the array misses, the side buffer is searched. A side-buffer hit moves the line into the array at the cost of exactly one extra cycle and sends nothing to the next level. A miss in both structures issues a single line refill to the next memory level and waits for it.

A build-time mode picks what the side buffer captures. In victim mode it keeps the valid line that a refill or a swap pushes out of the direct-mapped slot, and a buffer hit exchanges the two lines. In miss mode every refilled line goes into both the array and the buffer, and a buffer hit copies the line back into the array while the buffer keeps its copy. Buffer entries carry the whole line address, because any line may sit in any entry. Replacement uses empty entries first and otherwise evicts the least recently written entry. All lines are clean: there are no writes and no write-back.

Addresses are word addresses. The low log2(LINE_WORDS) bits select the word in a line, the next log2(SETS) bits select the set, and the rest form the tag. One request is handled at a time.

Top module: `vcache_top`

## Requirements
- R1: Reset clears every array slot and every buffer entry. Once reset is released, req_ready is 1 and resp_valid and fill_req_valid are 0, and the first read of any address is a full miss.
- R2: A direct-mapped hit raises resp_valid one cycle after the request is accepted (the accepting edge is when req_valid and req_ready are both 1). It returns the addressed word and makes no refill request.
- R3: When the array misses and the side buffer hits, the response comes two cycles after acceptance. That is exactly one cycle more than R2, and no refill request is made.
- R4: A miss in both structures raises fill_req_valid for exactly one cycle, one cycle after acceptance. fill_req_addr is the request address with its word-offset bits dropped. resp_valid rises on the edge that samples fill_resp_valid high, and it returns word k of fill_resp_data taken from bits [k*DATA_W +: DATA_W].
- R5: In victim mode (FILL_MODE = 0), a full miss puts the valid line displaced from the array slot into the buffer, and the requested line is not put there. A line is never present in both the array and the buffer.
- R6: In victim mode, a buffer hit places the requested line in the array and the displaced array line in that same buffer entry, so a later read of the displaced line is a buffer hit.
- R7: In miss mode (FILL_MODE = 1), a refill writes the requested line into both the array and the buffer. A buffer hit copies the line into the array, and the buffer keeps it.
- R8: A buffer insertion uses the lowest-numbered empty entry. When no entry is empty, it replaces the entry written least recently, where both insertions and buffer hits count as writes.
- R9: resp_valid is a one-cycle pulse for each accepted request. req_ready is 0 from the cycle after acceptance until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Block is idle and can accept a request |
| resp_valid | output | 1 | One-cycle pulse with read data |
| resp_data | output | DATA_W | Returned word |
| fill_req_valid | output | 1 | One-cycle refill request to the next level |
| fill_req_addr | output | ADDR_W-log2(LINE_WORDS) | Line address to refill |
| fill_resp_valid | input | 1 | Refill line is present |
| fill_resp_data | input | DATA_W*LINE_WORDS | Refill line, word 0 in the low bits |

## Verification
A wrong state in the array or the buffer appears at the ports as a latency class that differs from the expected one. A lost or duplicated buffer line, or a wrong LRU victim, turns an expected one-cycle-penalty hit into a refill, or the reverse. It also shows as a refill count that moves when it should not, or as a wrong word on resp_data. Such an error shows up on the first later read of the affected line. The request sequences are therefore built so that each swap, insertion and replacement is followed soon by a read that depends on it: one to three requests later, which is a few tens of cycles.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int DEF_ADDR_W     = 16;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_LINE_WORDS = 4;
    localparam int DEF_SETS       = 16;
    localparam int DEF_VB_ENTRIES = 4;

    // what the side buffer captures on a refill
    typedef enum logic {
        FILL_VICTIM = 1'b0,
        FILL_MISS   = 1'b1
    } fill_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SWAP,
        ST_WAIT
    } ctl_state_e;

    // index width that never collapses to zero
    function automatic int sel_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
    parameter int SETS   = vc_pkg::DEF_SETS,
    parameter int TAG_W  = 10,
    parameter int LINE_W = 128,
    localparam int IDX_W = vc_pkg::sel_w(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
    } dm_slot_t;

    dm_slot_t slot_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) slot_q[i].valid <= 1'b0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= '{valid: 1'b1, tag: wr_tag, line: wr_line};
        end
    end

    always_comb begin
        rd_valid = slot_q[rd_idx].valid;
        rd_tag   = slot_q[rd_idx].tag;
        rd_line  = slot_q[rd_idx].line;
    end

endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int ENTRIES = vc_pkg::DEF_VB_ENTRIES,
    localparam int WAY_W  = vc_pkg::sel_w(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               touch_en,
    input  logic [WAY_W-1:0]   touch_way,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [WAY_W-1:0]   alloc_way
);

    // recency rank per entry: 0 = most recent, ENTRIES-1 = oldest
    logic [WAY_W-1:0] rank_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= WAY_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (WAY_W'(i) == touch_way)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_way])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_way = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !found) begin
                alloc_way = WAY_W'(i);
                found     = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++)
                if (rank_q[i] == WAY_W'(ENTRIES - 1)) alloc_way = WAY_W'(i);
        end
    end

    // ranks must stay a permutation so exactly one entry is oldest
    logic [ENTRIES-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (int'(rank_q[i]) < ENTRIES) rank_seen[rank_q[i]] = 1'b1;
    end

    assert_rank_perm_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(rank_seen) == ENTRIES);

endmodule

// File: rtl/vc_vbuf.sv
module vc_vbuf #(
    parameter int ENTRIES = vc_pkg::DEF_VB_ENTRIES,
    parameter int LADDR_W = 14,
    parameter int LINE_W  = 128,
    localparam int WAY_W  = vc_pkg::sel_w(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic               lk_hit,
    output logic [WAY_W-1:0]   lk_way,
    output logic [LINE_W-1:0]  lk_line,
    output logic [WAY_W-1:0]   alloc_way,
    input  logic               wr_en,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic               wr_valid,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  logic [LINE_W-1:0]  wr_line
);

    typedef struct packed {
        logic               valid;
        logic [LADDR_W-1:0] laddr;
        logic [LINE_W-1:0]  line;
    } vb_entry_t;

    vb_entry_t          ent_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] valid_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[g].valid <= 1'b0;
            else if (wr_en && wr_way == WAY_W'(g))
                ent_q[g] <= '{valid: wr_valid, laddr: wr_laddr, line: wr_line};
        end
        assign match[g]     = ent_q[g].valid && (ent_q[g].laddr == lk_laddr);
        assign valid_vec[g] = ent_q[g].valid;
    end

    always_comb begin
        lk_way  = '0;
        lk_line = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_way  = WAY_W'(i);
                lk_line = ent_q[i].line;
            end
        end
    end

    assign lk_hit = |match;

    vc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (wr_en),
        .touch_way (wr_way),
        .valid_vec (valid_vec),
        .alloc_way (alloc_way)
    );

    // a line address never lives in two entries
    assert_unique_line_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/vcache_top.sv
module vcache_top
    import vc_pkg::*;
#(
    parameter int         ADDR_W     = DEF_ADDR_W,
    parameter int         DATA_W     = DEF_DATA_W,
    parameter int         LINE_WORDS = DEF_LINE_WORDS,
    parameter int         SETS       = DEF_SETS,
    parameter int         VB_ENTRIES = DEF_VB_ENTRIES,
    parameter fill_mode_e FILL_MODE  = FILL_VICTIM,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = DATA_W * LINE_WORDS,
    localparam int WAY_W   = sel_w(VB_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_data,
    output logic               fill_req_valid,
    output logic [LADDR_W-1:0] fill_req_addr,
    input  logic               fill_resp_valid,
    input  logic [LINE_W-1:0]  fill_resp_data
);

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_data_q;
    logic              fill_req_valid_q;

    logic [OFF_W-1:0]   off;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic [LADDR_W-1:0] laddr;

    assign off   = addr_q[OFF_W-1:0];
    assign idx   = addr_q[OFF_W +: IDX_W];
    assign tag   = addr_q[ADDR_W-1 -: TAG_W];
    assign laddr = addr_q[ADDR_W-1:OFF_W];

    function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] l,
                                                    input logic [OFF_W-1:0]  o);
        return l[int'(o)*DATA_W +: DATA_W];
    endfunction

    // direct-mapped array
    logic              dm_valid;
    logic [TAG_W-1:0]  dm_tag;
    logic [LINE_W-1:0] dm_line;
    logic              dm_wr_en;
    logic [LINE_W-1:0] dm_wr_line;
    logic              dm_hit;

    vc_dm_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_dm (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_valid (dm_valid),
        .rd_tag   (dm_tag),
        .rd_line  (dm_line),
        .wr_en    (dm_wr_en),
        .wr_idx   (idx),
        .wr_tag   (tag),
        .wr_line  (dm_wr_line)
    );

    assign dm_hit = dm_valid && (dm_tag == tag);

    // side buffer
    logic               vb_hit;
    logic [WAY_W-1:0]   vb_way;
    logic [LINE_W-1:0]  vb_line;
    logic [WAY_W-1:0]   vb_alloc;
    logic               vb_wr_en;
    logic [WAY_W-1:0]   vb_wr_way;
    logic               vb_wr_valid;
    logic [LADDR_W-1:0] vb_wr_laddr;
    logic [LINE_W-1:0]  vb_wr_line;

    vc_vbuf #(.ENTRIES(VB_ENTRIES), .LADDR_W(LADDR_W), .LINE_W(LINE_W)) u_vb (
        .clk       (clk),
        .rst       (rst),
        .lk_laddr  (laddr),
        .lk_hit    (vb_hit),
        .lk_way    (vb_way),
        .lk_line   (vb_line),
        .alloc_way (vb_alloc),
        .wr_en     (vb_wr_en),
        .wr_way    (vb_wr_way),
        .wr_valid  (vb_wr_valid),
        .wr_laddr  (vb_wr_laddr),
        .wr_line   (vb_wr_line)
    );

    // array and buffer update for swaps and refills
    always_comb begin
        dm_wr_en    = 1'b0;
        dm_wr_line  = fill_resp_data;
        vb_wr_en    = 1'b0;
        vb_wr_way   = vb_alloc;
        vb_wr_valid = 1'b1;
        vb_wr_laddr = laddr;
        vb_wr_line  = fill_resp_data;
        case (state_q)
            ST_SWAP: begin
                dm_wr_en   = 1'b1;
                dm_wr_line = vb_line;
                vb_wr_en   = 1'b1;
                vb_wr_way  = vb_way;
                if (FILL_MODE == FILL_VICTIM) begin
                    vb_wr_valid = dm_valid;
                    vb_wr_laddr = {dm_tag, idx};
                    vb_wr_line  = dm_line;
                end else begin
                    vb_wr_line  = vb_line;
                end
            end
            ST_WAIT: begin
                if (fill_resp_valid) begin
                    dm_wr_en = 1'b1;
                    if (FILL_MODE == FILL_VICTIM) begin
                        vb_wr_en    = dm_valid;
                        vb_wr_laddr = {dm_tag, idx};
                        vb_wr_line  = dm_line;
                    end else begin
                        vb_wr_en    = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // control
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q          <= ST_IDLE;
            addr_q           <= '0;
            resp_valid_q     <= 1'b0;
            resp_data_q      <= '0;
            fill_req_valid_q <= 1'b0;
        end else begin
            resp_valid_q     <= 1'b0;
            fill_req_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (dm_hit) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= pick_word(dm_line, off);
                        state_q      <= ST_IDLE;
                    end else if (vb_hit) begin
                        state_q <= ST_SWAP;
                    end else begin
                        fill_req_valid_q <= 1'b1;
                        state_q          <= ST_WAIT;
                    end
                end
                ST_SWAP: begin
                    resp_valid_q <= 1'b1;
                    resp_data_q  <= pick_word(vb_line, off);
                    state_q      <= ST_IDLE;
                end
                ST_WAIT: begin
                    if (fill_resp_valid) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= pick_word(fill_resp_data, off);
                        state_q      <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (state_q == ST_IDLE);
    assign resp_valid     = resp_valid_q;
    assign resp_data      = resp_data_q;
    assign fill_req_valid = fill_req_valid_q;
    assign fill_req_addr  = laddr;

    assert_hit_resp_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && dm_hit) |=> (resp_valid && !fill_req_valid));

    assert_side_hit_extra_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && !dm_hit && vb_hit)
            |=> (!resp_valid && !fill_req_valid) ##1 resp_valid);

    assert_fill_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && !dm_hit && !vb_hit) |=> fill_req_valid);

    assert_fill_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid |=> !fill_req_valid);

    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    if (FILL_MODE == FILL_VICTIM) begin : g_victim_chk
        assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
            (state_q == ST_LOOK && dm_hit) |-> !vb_hit);
    end

endmodule

// File: tb/vcache_top_tb.sv
module vcache_top_tb;
    import vc_pkg::*;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int OFF_W    = 2;
    localparam int LINE_W   = DATA_W * 4;
    localparam int LADDR_W  = ADDR_W - OFF_W;
    localparam int FILL_LAT = 6;
    localparam int LAT_MISS = FILL_LAT + 2;

    localparam logic [1:0] C_HIT = 2'd0, C_VB = 2'd1, C_MISS = 2'd2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst;
    logic [1:0]         req_valid;
    logic [ADDR_W-1:0]  req_addr        [2];
    logic               req_ready       [2];
    logic               resp_valid      [2];
    logic [DATA_W-1:0]  resp_data       [2];
    logic               fill_req_valid  [2];
    logic [LADDR_W-1:0] fill_req_addr   [2];
    int                 fill_cnt        [2];
    logic [LADDR_W-1:0] last_fill       [2];

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input logic [LADDR_W-1:0] la);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < 4; k++) l[k*DATA_W +: DATA_W] = word_of({la, OFF_W'(k)});
        return l;
    endfunction

    // instance 0: victim mode, instance 1: miss mode
    for (genvar g = 0; g < 2; g++) begin : g_dut
        logic               frv = 1'b0;
        logic [LINE_W-1:0]  frd = '0;
        bit                 pend = 1'b0;
        int                 left = 0;
        int                 cnt = 0;
        logic [LADDR_W-1:0] pa = '0;

        vcache_top #(.FILL_MODE(fill_mode_e'(g))) u_dut (
            .clk             (clk),
            .rst             (rst),
            .req_valid       (req_valid[g]),
            .req_addr        (req_addr[g]),
            .req_ready       (req_ready[g]),
            .resp_valid      (resp_valid[g]),
            .resp_data       (resp_data[g]),
            .fill_req_valid  (fill_req_valid[g]),
            .fill_req_addr   (fill_req_addr[g]),
            .fill_resp_valid (frv),
            .fill_resp_data  (frd)
        );

        // next-level memory with a fixed refill delay
        always @(negedge clk) begin
            frv = 1'b0;
            if (rst) begin
                pend = 1'b0;
            end else if (fill_req_valid[g]) begin
                pend = 1'b1;
                left = FILL_LAT;
                pa   = fill_req_addr[g];
                cnt++;
            end else if (pend) begin
                left--;
                if (left == 0) begin
                    frv  = 1'b1;
                    frd  = line_of(pa);
                    pend = 1'b0;
                end
            end
        end

        assign fill_cnt[g]  = cnt;
        assign last_fill[g] = pa;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input int sel, input logic [ADDR_W-1:0] addr,
                          input logic [1:0] cls, input string rq);
        int lat;
        int f0;
        int exp_lat;
        logic [DATA_W-1:0] got;
        @(negedge clk);
        chk(req_ready[sel] == 1'b1, rq, "ready before request", 64'(req_ready[sel]), 64'd1);
        f0 = fill_cnt[sel];
        req_valid[sel] = 1'b1;
        req_addr[sel]  = addr;
        @(negedge clk);
        req_valid[sel] = 1'b0;
        chk(req_ready[sel] == 1'b0, "R9", "busy after accept", 64'(req_ready[sel]), 64'd0);
        lat = 0;
        while (!resp_valid[sel] && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        got     = resp_data[sel];
        exp_lat = (cls == C_HIT) ? 1 : (cls == C_VB) ? 2 : LAT_MISS;
        chk(lat == exp_lat, rq, $sformatf("latency u%0d addr %h", sel, addr),
            64'(lat), 64'(exp_lat));
        chk(got == word_of(addr), rq, $sformatf("data u%0d addr %h", sel, addr),
            64'(got), 64'(word_of(addr)));
        chk((fill_cnt[sel] - f0) == ((cls == C_MISS) ? 1 : 0), rq, "refill count",
            64'(fill_cnt[sel] - f0), (cls == C_MISS) ? 64'd1 : 64'd0);
        if (cls == C_MISS)
            chk(last_fill[sel] == addr[ADDR_W-1:OFF_W], "R4", "fill address",
                64'(last_fill[sel]), 64'(addr[ADDR_W-1:OFF_W]));
        @(negedge clk);
        chk(!resp_valid[sel], "R9", "response is one pulse", 64'(resp_valid[sel]), 64'd0);
    endtask

    task automatic check_idle(input string rq);
        for (int s = 0; s < 2; s++) begin
            chk(req_ready[s] == 1'b1, rq, "ready after reset", 64'(req_ready[s]), 64'd1);
            chk(!resp_valid[s], rq, "no response after reset", 64'(resp_valid[s]), 64'd0);
            chk(!fill_req_valid[s], rq, "no refill after reset", 64'(fill_req_valid[s]), 64'd0);
        end
    endtask

    typedef struct packed {
        logic        sel;
        logic [15:0] addr;
        logic [1:0]  cls;
        logic [3:0]  rq;
    } vec_t;

    // lines A..F share set 0 (word addresses 0x00,0x40,...), G is in set 1
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        // victim mode
        '{1'b0, 16'h0000, 2'd2, 4'd1},  // R1 A cold miss
        '{1'b0, 16'h0001, 2'd0, 4'd2},  // R2 A hit
        '{1'b0, 16'h0042, 2'd2, 4'd5},  // R5 B miss, A displaced to buffer
        '{1'b0, 16'h0003, 2'd1, 4'd5},  // R5 A found in buffer
        '{1'b0, 16'h0041, 2'd1, 4'd6},  // R6 B swapped out earlier
        '{1'b0, 16'h0043, 2'd0, 4'd6},  // R6 B back in array
        '{1'b0, 16'h0080, 2'd2, 4'd5},  // R5 C
        '{1'b0, 16'h00C1, 2'd2, 4'd5},  // R5 D
        '{1'b0, 16'h0102, 2'd2, 4'd8},  // R8 E fills last empty entry
        '{1'b0, 16'h0143, 2'd2, 4'd8},  // R8 F evicts oldest (A)
        '{1'b0, 16'h0000, 2'd2, 4'd8},  // R8 A gone
        '{1'b0, 16'h0081, 2'd1, 4'd8},  // R8 C still buffered
        '{1'b0, 16'h0042, 2'd2, 4'd8},  // R8 B was replaced
        '{1'b0, 16'h00C0, 2'd2, 4'd8},  // R8 D was replaced
        '{1'b0, 16'h0083, 2'd1, 4'd6},  // R6 C swapped in again
        '{1'b0, 16'h0005, 2'd2, 4'd4},  // R4 G other set
        '{1'b0, 16'h0006, 2'd0, 4'd2},  // R2 G hit
        // miss mode
        '{1'b1, 16'h0000, 2'd2, 4'd1},  // R1 A cold miss
        '{1'b1, 16'h0002, 2'd0, 4'd2},  // R2 A hit
        '{1'b1, 16'h0041, 2'd2, 4'd7},  // R7 B
        '{1'b1, 16'h0003, 2'd1, 4'd7},  // R7 A refilled into buffer
        '{1'b1, 16'h0040, 2'd1, 4'd7},  // R7 B
        '{1'b1, 16'h0001, 2'd1, 4'd7},  // R7 buffer kept A after copy
        '{1'b1, 16'h0080, 2'd2, 4'd7},  // R7 C
        '{1'b1, 16'h00C0, 2'd2, 4'd7},  // R7 D
        '{1'b1, 16'h0101, 2'd2, 4'd8},  // R8 E evicts oldest (B)
        '{1'b1, 16'h0042, 2'd2, 4'd8},  // R8 B gone
        '{1'b1, 16'h0000, 2'd2, 4'd8},  // R8 A replaced by B
        '{1'b1, 16'h00C3, 2'd1, 4'd8},  // R8 D kept
        '{1'b1, 16'h00C1, 2'd0, 4'd2}   // R2 D in array
    };

    initial begin
        rst = 1'b1;
        req_valid = '0;
        req_addr[0] = '0;
        req_addr[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        for (int i = 0; i < NV; i++)
            do_req(int'(VEC[i].sel), VEC[i].addr, VEC[i].cls, $sformatf("R%0d", VEC[i].rq));

        // R1: reset empties both structures
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        do_req(0, 16'h0006, C_MISS, "R1");
        do_req(0, 16'h0083, C_MISS, "R1");
        do_req(1, 16'h00C1, C_MISS, "R1");
        do_req(1, 16'h00C2, C_HIT, "R2");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule